// File: doc/BRIEF.md
# Pipelined Dual Crossbar Matcher with Look-Ahead

This block schedules a crossbar that moves up to two cells per input and per output in every time slot. A single slot produces two matchings. The first covers the cell at the front of each per-output queue of every input. The second covers the cell just behind it, so it sees the queues one cell deeper. Both matchings run the same fixed number of two-step round-robin iterations: the request phase makes each input pick one output, and the grant phase makes each output pick one requester. There is no separate accept step.

One request stage and one grant stage are shared by the two matchings, offset by one cycle. In each cycle one matching makes its requests while the other settles its grants. Each matching keeps its own matched set and its own round-robin pointers.

An optional rescheduling mode lets a front cell that has lost its chance in the first matching compete in the second matching. When it wins there, it is reported as the cell to remove. The results are level outputs with a valid flag for each matching. A result has no ready handshake and holds its value until the next slot is accepted, so the consumer needs no back-pressure.

Top module: `hsm_dual_matcher`

## Requirements
- R1: After reset, `hol_valid`, `sol_valid` and `busy` are 0, `hol_match`, `sol_match` and `sol_head` are all zero, and every round-robin pointer is 0.
- R2: `slot_start` is taken only while `busy` is 0. When taken, it captures `voq_count` and `resched_en`, clears both matchings and both valids, and raises `busy`. A `slot_start` seen while `busy` is 1 has no effect on any output.
- R3: Count the edges from the edge that takes `slot_start`. `hol_valid` rises at edge 2*ITERS and `sol_valid` rises at edge 2*ITERS+1, where `busy` falls. Both valids stay high until the next slot is taken.
- R4: In the first matching, bit i*N+j of `hol_match` means input i is matched to output j. Each input and each output appears at most once. A pair can match only if its count is at least 1. The count of queue (input i, output j) is `voq_count[(i*N+j)*CW +: CW]`.
- R5: The second matching uses the same bit layout in `sol_match`, with at most one match per input and per output. A queue with a count of at least 2 is always eligible. The matched set of the second matching is kept apart from that of the first.
- R6: In each iteration, every unmatched input requests the first eligible unmatched output at or after its request pointer, counting upward and wrapping. Every unmatched output then grants the first requesting input at or after its grant pointer.
- R7: Pointers move only on grants made in the first iteration of a slot, and they take effect from the next iteration. For a grant from input i to output j, the request pointer of i becomes (j+1) mod N and the grant pointer of j becomes (i+1) mod N. Each matching has its own pointers, and the pointers keep their values from one slot to the next.
- R8: In every cycle from 1 to 2*ITERS-1 of a slot, the request stage and the grant stage are both working, each on a different matching.
- R9: With rescheduling on, iteration k of the second matching also treats a queue with a count of at least 1 as eligible when its input or its output is already matched to another partner in the first matching after k of its iterations.
- R10: Bit i*N+j of `sol_head` is 1 exactly when rescheduling is on for the slot, the pair is in `sol_match` and the pair is not in `hol_match`. In that case the front cell is the one to remove.
- R11: With rescheduling off, a queue with a count of 1 never appears in `sol_match`, and `sol_head` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_start | input | 1 | Starts a slot when idle |
| resched_en | input | 1 | Enables front-cell retry in the second matching |
| voq_count | input | N*N*CW | Cell count per queue, slice (i*N+j)*CW |
| busy | output | 1 | Slot in progress |
| hol_valid | output | 1 | First matching final |
| hol_match | output | N*N | First matching, bit i*N+j |
| sol_valid | output | 1 | Second matching final |
| sol_match | output | N*N | Second matching, bit i*N+j |
| sol_head | output | N*N | Second-matching winners that remove the front cell |

## Verification
Results are counted in clock edges from the edge that accepts `slot_start`:
- The first matching is final after 2*ITERS edges.
- The second matching is final one edge after that.

The bench drives the inputs at falling edges and counts each rising edge after acceptance. At every falling edge in between it compares both valid flags and `busy` with the expected state. It compares the three match vectors only at the falling edge after edge 2*ITERS+1, against a step-by-step model of both interleaved matchings. That model also steps the pointers forward in the same order as the hardware. In some slots the bench pulses `slot_start` again with different counts during cycle 2 and confirms that neither the timing nor the results change.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  typedef enum logic {
    SEL_HOL = 1'b0,
    SEL_SOL = 1'b1
  } match_sel_e;
endpackage

// File: rtl/hsm_rr_pick.sv
module hsm_rr_pick #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt
);
  logic          found;
  logic [PW-1:0] idx;

  // first set bit at or after ptr, wrapping
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = PW'((32'(ptr) + 32'(k)) % N);
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hsm_req_stage.sv
module hsm_req_stage #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*N-1:0]  elig,
  input  logic [N-1:0]    in_free,
  input  logic [N*PW-1:0] ptrs,
  output logic [N*N-1:0]  req
);
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [N-1:0] row;
    assign row = elig[i*N +: N] & {N{in_free[i]}};
    hsm_rr_pick #(.N(N)) u_pick (
      .req(row),
      .ptr(ptrs[i*PW +: PW]),
      .gnt(req[i*N +: N])
    );
  end
endmodule

// File: rtl/hsm_gnt_stage.sv
module hsm_gnt_stage #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*N-1:0]  req,
  input  logic [N-1:0]    out_free,
  input  logic [N*PW-1:0] ptrs,
  output logic [N*N-1:0]  gnt
);
  for (genvar j = 0; j < N; j++) begin : g_col
    logic [N-1:0] col;
    logic [N-1:0] pick;
    always_comb begin
      for (int i = 0; i < N; i++) col[i] = req[i*N+j] & out_free[j];
    end
    hsm_rr_pick #(.N(N)) u_pick (
      .req(col),
      .ptr(ptrs[j*PW +: PW]),
      .gnt(pick)
    );
    for (genvar i = 0; i < N; i++) begin : g_sc
      assign gnt[i*N+j] = pick[i];
    end
  end
endmodule

// File: rtl/hsm_dual_matcher.sv
module hsm_dual_matcher #(
  parameter int N     = 4,
  parameter int CW    = 4,
  parameter int ITERS = 3,
  localparam int PW   = (N > 1) ? $clog2(N) : 1,
  localparam int NN   = N * N,
  localparam int LAST = 2 * ITERS,
  localparam int TW   = $clog2(LAST + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic             resched_en,
  input  logic [NN*CW-1:0] voq_count,
  output logic             busy,
  output logic             hol_valid,
  output logic [NN-1:0]    hol_match,
  output logic             sol_valid,
  output logic [NN-1:0]    sol_match,
  output logic [NN-1:0]    sol_head
);
  import hsm_pkg::*;

  logic             busy_q, hol_v_q, sol_v_q, res_q;
  logic [TW-1:0]    cnt_q;
  logic [NN*CW-1:0] occ_q;
  logic [NN-1:0]    hol_q, sol_q;
  logic [NN-1:0]    req_q;
  logic             req_v_q, req_it0_q;
  match_sel_e       req_sel_q;
  logic [N*PW-1:0]  rptr_q [2];
  logic [N*PW-1:0]  gptr_q [2];

  logic [NN-1:0] has1, has2;
  logic [N-1:0]  hol_in_busy, hol_out_busy, sol_in_busy, sol_out_busy;
  logic [NN-1:0] elig_hol, elig_sol;
  logic          req_act;
  match_sel_e    req_sel;
  logic [NN-1:0] req_elig, req_vec, gnt_vec;
  logic [N-1:0]  req_in_free, gnt_out_free;

  // queue occupancy thresholds
  always_comb begin
    for (int k = 0; k < NN; k++) begin
      has1[k] = occ_q[k*CW +: CW] != '0;
      has2[k] = occ_q[k*CW +: CW] >= CW'(2);
    end
  end

  // matched rows / columns of both matchings
  always_comb begin
    hol_in_busy = '0; hol_out_busy = '0;
    sol_in_busy = '0; sol_out_busy = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (hol_q[i*N+j]) begin hol_in_busy[i] = 1'b1; hol_out_busy[j] = 1'b1; end
        if (sol_q[i*N+j]) begin sol_in_busy[i] = 1'b1; sol_out_busy[j] = 1'b1; end
      end
    end
  end

  // eligibility per matching
  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        elig_hol[i*N+j] = has1[i*N+j] & ~hol_out_busy[j];
        elig_sol[i*N+j] = (has2[i*N+j] |
                           (res_q & has1[i*N+j] & ~hol_q[i*N+j] &
                            (hol_in_busy[i] | hol_out_busy[j]))) & ~sol_out_busy[j];
      end
    end
  end

  // even cycles: first matching requests, odd cycles: second matching requests
  assign req_act     = busy_q && (cnt_q < TW'(LAST));
  assign req_sel     = cnt_q[0] ? SEL_SOL : SEL_HOL;
  assign req_elig    = (req_sel == SEL_SOL) ? elig_sol : elig_hol;
  assign req_in_free = (req_sel == SEL_SOL) ? ~sol_in_busy : ~hol_in_busy;
  assign gnt_out_free = (req_sel_q == SEL_SOL) ? ~sol_out_busy : ~hol_out_busy;

  hsm_req_stage #(.N(N)) u_req (
    .elig   (req_elig),
    .in_free(req_in_free),
    .ptrs   (rptr_q[req_sel]),
    .req    (req_vec)
  );

  hsm_gnt_stage #(.N(N)) u_gnt (
    .req     (req_q),
    .out_free(gnt_out_free),
    .ptrs    (gptr_q[req_sel_q]),
    .gnt     (gnt_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      hol_v_q   <= 1'b0;
      sol_v_q   <= 1'b0;
      res_q     <= 1'b0;
      cnt_q     <= '0;
      occ_q     <= '0;
      hol_q     <= '0;
      sol_q     <= '0;
      req_q     <= '0;
      req_v_q   <= 1'b0;
      req_it0_q <= 1'b0;
      req_sel_q <= SEL_HOL;
      for (int m = 0; m < 2; m++) begin
        rptr_q[m] <= '0;
        gptr_q[m] <= '0;
      end
    end else if (!busy_q) begin
      if (slot_start) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        occ_q   <= voq_count;
        res_q   <= resched_en;
        hol_q   <= '0;
        sol_q   <= '0;
        hol_v_q <= 1'b0;
        sol_v_q <= 1'b0;
        req_v_q <= 1'b0;
      end
    end else begin
      cnt_q     <= cnt_q + TW'(1);
      req_v_q   <= req_act;
      req_q     <= req_vec;
      req_sel_q <= req_sel;
      req_it0_q <= cnt_q < TW'(2);
      if (req_v_q) begin
        if (req_sel_q == SEL_SOL) sol_q <= sol_q | gnt_vec;
        else                      hol_q <= hol_q | gnt_vec;
        if (req_it0_q) begin
          for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
              if (gnt_vec[i*N+j]) begin
                rptr_q[req_sel_q][i*PW +: PW] <= PW'((j + 1) % N);
                gptr_q[req_sel_q][j*PW +: PW] <= PW'((i + 1) % N);
              end
            end
          end
        end
      end
      if (cnt_q == TW'(LAST - 1)) hol_v_q <= 1'b1;
      if (cnt_q == TW'(LAST)) begin
        sol_v_q <= 1'b1;
        busy_q  <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign hol_valid = hol_v_q;
  assign sol_valid = sol_v_q;
  assign hol_match = hol_q;
  assign sol_match = sol_q;
  assign sol_head  = sol_q & ~hol_q & {NN{res_q}};

  // ---------------- assertions ----------------
  for (genvar g = 0; g < N; g++) begin : g_chk
    logic [N-1:0] hcol, scol;
    always_comb begin
      for (int i = 0; i < N; i++) begin
        hcol[i] = hol_q[i*N+g];
        scol[i] = sol_q[i*N+g];
      end
    end
    // R4
    hol_row_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hol_q[g*N +: N]));
    // R4
    hol_col_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hcol));
    // R5
    sol_row_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sol_q[g*N +: N]));
    // R5
    sol_col_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(scol));
  end

  // R4
  hol_needs_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hol_q & ~has1) == '0);
  // R11
  sol_no_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_q |-> ((sol_q & ~has2) == '0));
  // R3
  sol_after_hol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hol_v_q) |=> $rose(sol_v_q));
  // R8
  both_stages_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q >= TW'(1) && cnt_q < TW'(LAST)) |-> (req_act && req_v_q && req_sel != req_sel_q));
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && slot_start) |=> ($stable(occ_q) && $stable(res_q)));
endmodule

// File: tb/hsm_dual_matcher_test.sv
`timescale 1ns/1ps
module hsm_dual_matcher_test;
  localparam int N     = 4;
  localparam int CW    = 4;
  localparam int ITERS = 3;
  localparam int NN    = N * N;
  localparam int LAST  = 2 * ITERS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             slot_start = 1'b0;
  logic             resched_en = 1'b0;
  logic [NN*CW-1:0] voq_count = '0;
  logic             busy, hol_valid, sol_valid;
  logic [NN-1:0]    hol_match, sol_match, sol_head;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int brp [2][N];
  int bgp [2][N];
  logic [NN-1:0] e_hol, e_sol, e_head;

  always #4 clk = ~clk;

  hsm_dual_matcher #(.N(N), .CW(CW), .ITERS(ITERS)) uut (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .resched_en(resched_en),
    .voq_count(voq_count), .busy(busy), .hol_valid(hol_valid), .hol_match(hol_match),
    .sol_valid(sol_valid), .sol_match(sol_match), .sol_head(sol_head)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic int qcnt(input logic [NN*CW-1:0] oc, input int k);
    return int'(oc[k*CW +: CW]);
  endfunction

  function automatic bit row_busy(input logic [NN-1:0] m, input int i);
    return |m[i*N +: N];
  endfunction

  function automatic bit col_busy(input logic [NN-1:0] m, input int j);
    bit b = 0;
    for (int i = 0; i < N; i++) b |= m[i*N+j];
    return b;
  endfunction

  // one round-robin request/grant iteration (R6, R7)
  task automatic iterate(input int m, inout logic [NN-1:0] mat, input logic [NN-1:0] el, input bit first);
    logic [NN-1:0] rq = '0;
    logic [NN-1:0] g = '0;
    for (int i = 0; i < N; i++) begin
      if (!row_busy(mat, i)) begin
        for (int t = 0; t < N; t++) begin
          int j = (brp[m][i] + t) % N;
          if (el[i*N+j] && !col_busy(mat, j)) begin rq[i*N+j] = 1'b1; break; end
        end
      end
    end
    for (int j = 0; j < N; j++) begin
      if (!col_busy(mat, j)) begin
        for (int t = 0; t < N; t++) begin
          int i = (bgp[m][j] + t) % N;
          if (rq[i*N+j]) begin g[i*N+j] = 1'b1; break; end
        end
      end
    end
    mat |= g;
    if (first) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (g[i*N+j]) begin brp[m][i] = (j + 1) % N; bgp[m][j] = (i + 1) % N; end
    end
  endtask

  task automatic model_slot(input logic [NN*CW-1:0] oc, input bit rs);
    logic [NN-1:0] hm = '0;
    logic [NN-1:0] sm = '0;
    logic [NN-1:0] he, se;
    for (int k = 0; k < ITERS; k++) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          int c = qcnt(oc, i*N+j);
          he[i*N+j] = c >= 1;
          se[i*N+j] = (c >= 2) || (rs && c >= 1 && !hm[i*N+j] &&
                                   (row_busy(hm, i) || col_busy(hm, j)));   // R9
        end
      end
      iterate(0, hm, he, k == 0);
      iterate(1, sm, se, k == 0);
    end
    e_hol  = hm;
    e_sol  = sm;
    e_head = rs ? (sm & ~hm) : '0;   // R10
  endtask

  task automatic run_slot(input logic [NN*CW-1:0] oc, input bit rs, input bit poke);
    @(negedge clk);
    slot_start = 1'b1; voq_count = oc; resched_en = rs;
    @(posedge clk);
    @(negedge clk);
    slot_start = 1'b0;
    model_slot(oc, rs);
    for (int m = 0; m <= LAST + 1; m++) begin
      if (m > 0) begin @(posedge clk); @(negedge clk); end
      chk(hol_valid == (m >= LAST), "R3 hol_valid", 64'(hol_valid), 64'(m >= LAST));
      chk(sol_valid == (m >= LAST + 1), "R3 sol_valid", 64'(sol_valid), 64'(m >= LAST + 1));
      chk(busy == (m < LAST + 1), "R2 busy", 64'(busy), 64'(m < LAST + 1));
      if (poke && m == 2) begin
        slot_start = 1'b1; voq_count = ~oc; resched_en = ~rs;   // R2 ignored while busy
      end else begin
        slot_start = 1'b0;
      end
    end
    chk(hol_match == e_hol, "R4 hol_match", 64'(hol_match), 64'(e_hol));
    chk(sol_match == e_sol, "R5 sol_match", 64'(sol_match), 64'(e_sol));
    chk(sol_head == e_head, "R10 sol_head", 64'(sol_head), 64'(e_head));
    if (!rs) chk(sol_head == '0, "R11 sol_head off", 64'(sol_head), 64'(0));
    // R3 results hold while idle
    @(posedge clk); @(negedge clk);
    chk(hol_valid && sol_valid && hol_match == e_hol, "R3 hold", 64'(hol_match), 64'(e_hol));
  endtask

  function automatic logic [NN*CW-1:0] fill(input int v);
    logic [NN*CW-1:0] r;
    for (int k = 0; k < NN; k++) r[k*CW +: CW] = CW'(v);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NN*CW-1:0] oc;
    void'($urandom(32'd7));
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < N; i++) begin brp[m][i] = 0; bgp[m][i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!hol_valid && !sol_valid && !busy, "R1 flags", {hol_valid, sol_valid, busy}, 0);
    chk(hol_match == 0 && sol_match == 0 && sol_head == 0, "R1 matches", 64'(hol_match | sol_match), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !hol_valid, "R1 idle", 64'(busy), 0);

    // directed: empty queues
    run_slot('0, 1'b1, 1'b0);
    // directed: all counts 1, rescheduling off (R11) then on (R9)
    run_slot(fill(1), 1'b0, 1'b0);
    run_slot(fill(1), 1'b1, 1'b0);
    // directed: all counts 2, both matchings full (R5, R6, R7)
    run_slot(fill(2), 1'b0, 1'b0);
    run_slot(fill(2), 1'b1, 1'b1);
    // directed: one hot column forces conflicts (R4, R9)
    oc = '0;
    for (int i = 0; i < N; i++) oc[(i*N)*CW +: CW] = CW'(1);
    run_slot(oc, 1'b1, 1'b0);
    run_slot(oc, 1'b0, 1'b1);
    // directed: full counters
    run_slot(fill((1 << CW) - 1), 1'b1, 1'b0);

    // constrained random
    for (int s = 0; s < 60; s++) begin
      for (int k = 0; k < NN; k++) begin
        int r = $urandom % 8;
        oc[k*CW +: CW] = (r < 3) ? CW'(0) : (r < 5) ? CW'(1) : (r < 7) ? CW'(2) : CW'($urandom);
      end
      run_slot(oc, 1'($urandom), (s % 5) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule